// File: doc/BRIEF.md
# Configuration Cycle Bridge Router

This block is the configuration-routing stage of a bridge that joins an upstream (primary) bus to a downstream (secondary) bus. Each configuration request that arrives on the primary side has a type flag, a target bus number, a device number, a function number and a register number. The block compares the target bus against its programmable bus-number registers. It then does one of three things: it passes the request downstream unchanged as a bus-numbered request, it rewrites the request as a local request for the bus directly below the bridge, or it drops the request.

Software fills three bus-number registers through a small write port: the number of the bus above the bridge, the number of the bus directly below it, and the highest-numbered bus anywhere below it. A bus counts as behind the bridge only when its number lies within the directly-below and highest-below numbers, both ends included. While the downstream tree is still being enumerated, software can set the highest-below number to 0xFF. When a request is rewritten for the directly attached bus, the block replaces the device number with a one-hot slot-select field in the 32-bit address. Every result is registered and appears one clock after the request.

Top module: `cfg_bridge_router`

## Requirements
- R1: A synchronous active-high reset clears all three bus-number registers to 0 and drives out_valid and out_ignore low. While sec_bus is 0, every request is dropped.
- R2: A write with wr_en high and wr_sel 0, 1 or 2 loads wr_data into pri_bus, sec_bus or sub_bus respectively, and the new value is visible on the port after the next clock edge. A write with wr_sel 3 changes none of the three registers.
- R3: A request with req_type1 low (a local request arriving on the primary side) is always dropped.
- R4: A request with req_type1 high and req_bus equal to sec_bus (with sec_bus within range) is emitted with out_type1 low. Its address has bit 11+req_dev set, every other bit of 31:11 clear, the function in bits 10:8, the register in bits 7:2, and bits 1:0 = 00.
- R5: A request that would be rewritten (see R4) but has req_dev greater than 20 has no select bit in 31:11 and is dropped.
- R6: A request with req_type1 high and sec_bus < req_bus <= sub_bus is emitted with out_type1 high. Its address has bits 31:24 = 0, the bus in 23:16, the device in 15:11, the function in 10:8, the register in 7:2, and bits 1:0 = 01.
- R7: A request with req_type1 high and req_bus below sec_bus or above sub_bus is dropped. With sub_bus at 0xFF, every bus from sec_bus upward is in range.
- R8: When sub_bus is less than sec_bus, the range is empty and every request is dropped, including one aimed at sec_bus itself.
- R9: Each request yields exactly one of out_valid or out_ignore, high for one cycle in the clock after req_valid. Both are low in a cycle that follows no request, and out_addr is 0 whenever out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus-number register write strobe |
| wr_sel | input | 2 | Register select: 0 upstream, 1 directly below, 2 highest below |
| wr_data | input | 8 | Bus number to write |
| pri_bus | output | 8 | Upstream bus number |
| sec_bus | output | 8 | Directly attached downstream bus number |
| sub_bus | output | 8 | Highest bus number below the bridge |
| req_valid | input | 1 | Request strobe |
| req_type1 | input | 1 | 1 = bus-numbered request, 0 = local request |
| req_bus | input | 8 | Target bus |
| req_dev | input | 5 | Target device |
| req_func | input | 3 | Target function |
| req_reg | input | 6 | Target register (dword index) |
| out_valid | output | 1 | Request emitted on the secondary side |
| out_type1 | output | 1 | Emitted request type: 1 bus-numbered, 0 local |
| out_addr | output | 32 | Emitted configuration address |
| out_ignore | output | 1 | Request dropped |

## Verification
A request sampled at one clock edge produces its outcome, address and type at the following edge. The bench therefore drives each request on a falling edge, withdraws it on the next falling edge, and reads the outputs at that point, one rising edge later. Register writes follow the same one-edge rule, so a programmed bus number is read back on the falling edge after the write. The idle check looks one further cycle on, to confirm that a single request does not leave a result standing.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  typedef enum logic [1:0] {
    ROUTE_DROP    = 2'd0,
    ROUTE_TO_T0   = 2'd1,
    ROUTE_PASS_T1 = 2'd2
  } route_e;

  localparam int unsigned NUM_BUSREGS = 3;
endpackage

// File: rtl/cbr_busregs.sv
module cbr_busregs #(
  parameter int unsigned BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [BUS_W-1:0] wr_data,
  output logic [BUS_W-1:0] pri_bus,
  output logic [BUS_W-1:0] sec_bus,
  output logic [BUS_W-1:0] sub_bus
);
  logic [BUS_W-1:0] regs_q [cbr_pkg::NUM_BUSREGS];

  for (genvar g = 0; g < int'(cbr_pkg::NUM_BUSREGS); g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[g] <= '0;
      end else if (wr_en && (wr_sel == 2'(g))) begin
        regs_q[g] <= wr_data;
      end
    end
  end

  assign pri_bus = regs_q[0];
  assign sec_bus = regs_q[1];
  assign sub_bus = regs_q[2];
endmodule

// File: rtl/cbr_decode.sv
module cbr_decode #(
  parameter int unsigned BUS_W     = 8,
  parameter int unsigned DEV_W     = 5,
  parameter int unsigned NUM_SLOTS = 21
) (
  input  logic                 is_type1,
  input  logic [BUS_W-1:0]     bus,
  input  logic [DEV_W-1:0]     dev,
  input  logic [BUS_W-1:0]     sec,
  input  logic [BUS_W-1:0]     sub,
  output cbr_pkg::route_e      route
);
  logic sec_set, in_range, is_local, slot_ok;

  assign sec_set  = (sec != '0);
  assign in_range = (bus >= sec) && (bus <= sub);
  assign is_local = (bus == sec);
  assign slot_ok  = (32'(dev) < NUM_SLOTS);

  always_comb begin
    route = cbr_pkg::ROUTE_DROP;
    if (is_type1 && sec_set && in_range) begin
      if (!is_local)    route = cbr_pkg::ROUTE_PASS_T1;
      else if (slot_ok) route = cbr_pkg::ROUTE_TO_T0;
    end
  end
endmodule

// File: rtl/cbr_addr_gen.sv
module cbr_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned DEV_W  = 5,
  parameter int unsigned FUNC_W = 3,
  parameter int unsigned REG_W  = 6
) (
  input  cbr_pkg::route_e   route,
  input  logic [BUS_W-1:0]  bus,
  input  logic [DEV_W-1:0]  dev,
  input  logic [FUNC_W-1:0] func,
  input  logic [REG_W-1:0]  reg_num,
  output logic [ADDR_W-1:0] addr
);
  localparam int unsigned REG_LSB  = 2;
  localparam int unsigned FUNC_LSB = REG_LSB + REG_W;
  localparam int unsigned SEL_LSB  = FUNC_LSB + FUNC_W;
  localparam int unsigned SEL_W    = ADDR_W - SEL_LSB;
  localparam int unsigned BUS_LSB  = SEL_LSB + DEV_W;

  logic [SEL_W-1:0] sel_vec;

  for (genvar g = 0; g < int'(SEL_W); g++) begin : g_sel
    assign sel_vec[g] = (32'(dev) == g);
  end

  always_comb begin
    addr = '0;
    unique case (route)
      cbr_pkg::ROUTE_TO_T0: begin
        addr[REG_LSB +: REG_W]   = reg_num;
        addr[FUNC_LSB +: FUNC_W] = func;
        addr[SEL_LSB +: SEL_W]   = sel_vec;
      end
      cbr_pkg::ROUTE_PASS_T1: begin
        addr[1:0]                = 2'b01;
        addr[REG_LSB +: REG_W]   = reg_num;
        addr[FUNC_LSB +: FUNC_W] = func;
        addr[SEL_LSB +: DEV_W]   = dev;
        addr[BUS_LSB +: BUS_W]   = bus;
      end
      default: addr = '0;
    endcase
  end
endmodule

// File: rtl/cfg_bridge_router.sv
module cfg_bridge_router #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned DEV_W  = 5,
  parameter int unsigned FUNC_W = 3,
  parameter int unsigned REG_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [BUS_W-1:0]  wr_data,
  output logic [BUS_W-1:0]  pri_bus,
  output logic [BUS_W-1:0]  sec_bus,
  output logic [BUS_W-1:0]  sub_bus,
  input  logic              req_valid,
  input  logic              req_type1,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [FUNC_W-1:0] req_func,
  input  logic [REG_W-1:0]  req_reg,
  output logic              out_valid,
  output logic              out_type1,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_ignore
);
  localparam int unsigned NUM_SLOTS = ADDR_W - (2 + REG_W + FUNC_W);

  cbr_pkg::route_e   route;
  logic [ADDR_W-1:0] addr_next;

  cbr_busregs #(.BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pri_bus(pri_bus), .sec_bus(sec_bus), .sub_bus(sub_bus)
  );

  cbr_decode #(.BUS_W(BUS_W), .DEV_W(DEV_W), .NUM_SLOTS(NUM_SLOTS)) u_dec (
    .is_type1(req_type1), .bus(req_bus), .dev(req_dev),
    .sec(sec_bus), .sub(sub_bus), .route(route)
  );

  cbr_addr_gen #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .DEV_W(DEV_W), .FUNC_W(FUNC_W), .REG_W(REG_W)
  ) u_addr (
    .route(route), .bus(req_bus), .dev(req_dev), .func(req_func),
    .reg_num(req_reg), .addr(addr_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_ignore <= 1'b0;
      out_type1  <= 1'b0;
      out_addr   <= '0;
    end else begin
      out_valid  <= req_valid && (route != cbr_pkg::ROUTE_DROP);
      out_ignore <= req_valid && (route == cbr_pkg::ROUTE_DROP);
      out_type1  <= req_valid && (route == cbr_pkg::ROUTE_PASS_T1);
      out_addr   <= req_valid ? addr_next : '0;
    end
  end
endmodule

// File: rtl/cbr_checker.sv
module cbr_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BUS_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [BUS_W-1:0]  sec_bus,
  input logic [BUS_W-1:0]  sub_bus,
  input logic              req_valid,
  input logic              req_type1,
  input logic              out_valid,
  input logic              out_type1,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_ignore
);
  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_ignore));

  assert_outcome_follows_req_R9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (out_valid || out_ignore));

  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !(out_valid || out_ignore));

  assert_local_dropped_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_type1) |=> out_ignore);

  assert_t0_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_type1) |->
      (out_addr[1:0] == 2'b00) && ($countones(out_addr[ADDR_W-1:11]) == 1));

  assert_t1_range_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_type1) |->
      (out_addr[1:0] == 2'b01) && (out_addr[23:16] > $past(sec_bus))
      && (out_addr[23:16] <= $past(sub_bus)));

  assert_idle_addr_R9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_addr == '0));
endmodule

bind cfg_bridge_router cbr_checker #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .sec_bus(sec_bus), .sub_bus(sub_bus),
  .req_valid(req_valid), .req_type1(req_type1), .out_valid(out_valid),
  .out_type1(out_type1), .out_addr(out_addr), .out_ignore(out_ignore)
);

// File: tb/tb_cfg_bridge_router.sv
module tb_cfg_bridge_router;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [7:0]  wr_data;
  logic [7:0]  pri_bus, sec_bus, sub_bus;
  logic        req_valid, req_type1;
  logic [7:0]  req_bus;
  logic [4:0]  req_dev;
  logic [2:0]  req_func;
  logic [5:0]  req_reg;
  logic        out_valid, out_type1, out_ignore;
  logic [31:0] out_addr;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_bridge_router dut (.*);

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", what, got, exp);
    end
  endtask

  function automatic logic [31:0] t0_addr(int dev, int func, int regn);
    return (32'h1 << (11 + dev)) | 32'(func << 8) | 32'(regn << 2);
  endfunction

  function automatic logic [31:0] t1_addr(int bus, int dev, int func, int regn);
    return 32'(bus << 16) | 32'(dev << 11) | 32'(func << 8) | 32'(regn << 2) | 32'h1;
  endfunction

  task automatic program_reg(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Drives one request and checks the outcome one rising edge later.
  task automatic send(input string tag, input logic t1, input int bus, input int dev,
                      input int func, input int regn, input int kind,
                      input logic [31:0] exp_addr);
    @(negedge clk);
    req_valid = 1'b1; req_type1 = t1; req_bus = 8'(bus); req_dev = 5'(dev);
    req_func = 3'(func); req_reg = 6'(regn);
    @(negedge clk);
    req_valid = 1'b0;
    // kind: 0 drop, 1 local rewrite, 2 pass-through
    chk({tag, " out_valid"},  32'(out_valid),  32'(kind != 0));
    chk({tag, " out_ignore"}, 32'(out_ignore), 32'(kind == 0));
    chk({tag, " out_type1"},  32'(out_type1),  32'(kind == 2));
    chk({tag, " out_addr"},   out_addr,        (kind == 0) ? 32'h0 : exp_addr);
  endtask

  task automatic t_reset;
    chk("R1 pri_bus reset", 32'(pri_bus), 0);
    chk("R1 sec_bus reset", 32'(sec_bus), 0);
    chk("R1 sub_bus reset", 32'(sub_bus), 0);
    chk("R1 out_valid reset", 32'(out_valid), 0);
    chk("R1 out_ignore reset", 32'(out_ignore), 0);
    send("R1 unprogrammed bus0", 1'b1, 0, 1, 0, 0, 0, 0);
  endtask

  task automatic t_regwrite;
    program_reg(2'd0, 8'd1);
    program_reg(2'd1, 8'd2);
    program_reg(2'd2, 8'd5);
    chk("R2 pri_bus", 32'(pri_bus), 1);
    chk("R2 sec_bus", 32'(sec_bus), 2);
    chk("R2 sub_bus", 32'(sub_bus), 5);
    program_reg(2'd3, 8'hAA);
    chk("R2 sel3 pri", 32'(pri_bus), 1);
    chk("R2 sel3 sec", 32'(sec_bus), 2);
    chk("R2 sel3 sub", 32'(sub_bus), 5);
  endtask

  task automatic t_local_in;
    send("R3 type0 at sec", 1'b0, 2, 1, 0, 0, 0, 0);
    send("R3 type0 in range", 1'b0, 4, 3, 2, 1, 0, 0);
  endtask

  task automatic t_convert;
    send("R4 slot0", 1'b1, 2, 0, 0, 0, 1, t0_addr(0, 0, 0));
    send("R4 slot20", 1'b1, 2, 20, 7, 63, 1, t0_addr(20, 7, 63));
    send("R4 slot3", 1'b1, 2, 3, 1, 5, 1, t0_addr(3, 1, 5));
  endtask

  task automatic t_high_slot;
    send("R5 slot21", 1'b1, 2, 21, 0, 0, 0, 0);
    send("R5 slot31", 1'b1, 2, 31, 4, 9, 0, 0);
  endtask

  task automatic t_forward;
    send("R6 bus3", 1'b1, 3, 7, 2, 10, 2, t1_addr(3, 7, 2, 10));
    send("R6 bus5 top", 1'b1, 5, 31, 7, 63, 2, t1_addr(5, 31, 7, 63));
  endtask

  task automatic t_outside;
    send("R7 below sec", 1'b1, 1, 2, 0, 0, 0, 0);
    send("R7 above sub", 1'b1, 6, 2, 0, 0, 0, 0);
    program_reg(2'd2, 8'hFF);
    send("R7 temp sub bus255", 1'b1, 255, 4, 3, 2, 2, t1_addr(255, 4, 3, 2));
    send("R7 temp sub bus1", 1'b1, 1, 4, 3, 2, 0, 0);
  endtask

  task automatic t_empty_range;
    program_reg(2'd1, 8'd9);
    program_reg(2'd2, 8'd4);
    send("R8 empty at sec", 1'b1, 9, 1, 0, 0, 0, 0);
    send("R8 empty mid", 1'b1, 5, 1, 0, 0, 0, 0);
  endtask

  task automatic t_idle;
    program_reg(2'd2, 8'd12);
    send("R9 single req", 1'b1, 9, 2, 0, 1, 1, t0_addr(2, 0, 1));
    @(negedge clk);
    chk("R9 idle out_valid", 32'(out_valid), 0);
    chk("R9 idle out_ignore", 32'(out_ignore), 0);
    chk("R9 idle out_addr", out_addr, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    req_valid = 1'b0; req_type1 = 1'b0; req_bus = '0; req_dev = '0;
    req_func = '0; req_reg = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regwrite();
    t_local_in();
    t_convert();
    t_high_slot();
    t_forward();
    t_outside();
    t_empty_range();
    t_idle();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule